// File: doc/BRIEF.md
# Bank-Group Background Refresh Controller

This block sequences background refresh for a four-bank memory whose banks are paired into two groups: group 0 holds banks 0 and 1, and group 1 holds banks 2 and 3. A refresh command starts on the command port. An address bit selects entry or exit. A group-select input picks the pair. The low ten address bits give the number of refresh cycles to run. While one pair is being refreshed, the block flags both of its banks as busy. The other pair stays free for normal reads and writes.

An exit command ends a running refresh early. The pair stays busy for one more refresh-cycle time and then returns to idle. The block rejects malformed or badly timed commands and raises a one-cycle error pulse for each. It also flags any access request that targets a busy bank. For each group it counts accepted entries over a fixed window and reports a group that fell short of the required number when the window closes. The refresh-cycle time, window length and quota are parameters given in clock cycles.

Top module: `bg_refresh_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `bank_busy`, all five error outputs and `quota_miss` are 0.
- R2: A command takes effect only in a cycle where `cmd_en` and `cmd_special` are both high. `cmd_addr[10]` = 0 means entry and `cmd_addr[10]` = 1 means exit. If either strobe is low, nothing changes and no flag is raised.
- R3: An accepted entry with `cmd_grp` = 0 marks banks 0 and 1 busy (`bank_busy` = 4'b0011). With `cmd_grp` = 1 it marks banks 2 and 3 busy (4'b1100). The other pair stays 0.
- R4: An accepted entry with count N = `cmd_addr[9:0]` keeps its pair busy from the cycle after the command for exactly N*TREFC cycles. The pair is then idle.
- R5: An entry whose count is 0 or above 31 (the full ten bits are compared) starts no refresh and pulses `err_count` for one cycle. This check has the highest priority.
- R6: An entry with a legal count while both groups are idle, where one of the target pair's `bank_pre` bits is 0, starts no refresh and pulses `err_precharge`.
- R7: An entry with a legal count while either group is busy (refreshing or draining), to either group, is ignored and pulses `err_overlap`. This check ranks below R5 and above R6. At most one group is ever busy.
- R8: An exit while a group is refreshing keeps that group busy for exactly TREFC cycles after the exit cycle and then idles it, whatever count remained.
- R9: An exit while no group is refreshing (all idle, or the active group already draining after an exit) changes no timing and pulses `err_exit`.
- R10: `acc_req` high with `bank_busy[acc_bank]` = 1 gives a one-cycle `err_access` pulse in the next cycle. A request to a non-busy bank gives none.
- R11: Every TREF_CYC cycles after reset a window closes. For one cycle, `quota_miss[g]` is 1 if group g had fewer than QUOTA accepted entries in that window. The per-group counter saturates at QUOTA and restarts with each window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_en | input | 1 | Command issue strobe |
| cmd_special | input | 1 | Special-address qualifier; must be high for refresh commands |
| cmd_addr | input | CNT_W+1 | Bit CNT_W: 0 entry / 1 exit; low CNT_W bits: refresh count |
| cmd_grp | input | 1 | Target pair: 0 = banks 0-1, 1 = banks 2-3 |
| bank_pre | input | 4 | Per-bank precharged status |
| acc_req | input | 1 | Read/write access request |
| acc_bank | input | 2 | Bank addressed by the access request |
| bank_busy | output | 4 | Per-bank busy due to background refresh |
| err_count | output | 1 | Illegal refresh count pulse |
| err_overlap | output | 1 | Entry while a group is busy pulse |
| err_precharge | output | 1 | Target pair not precharged pulse |
| err_exit | output | 1 | Exit with no refresh running pulse |
| err_access | output | 1 | Access to a busy bank pulse |
| quota_miss | output | 2 | Per-group quota shortfall pulse at window close |

## Verification
The bench builds the block with TREFC = 3, TREF_CYC = 200 and QUOTA = 4. This makes every legal count from 1 to 31 affordable for both groups, at no more than 93 busy cycles each, so the busy duration is swept exhaustively and compared with N*3 cycle by cycle. A short window and a small quota let two complete windows, one with a saturating group, be checked at their exact closing cycles. Out-of-range counts, including values whose low five bits would look legal, are swept next to the legal ones.

// File: rtl/bgr_pkg.sv
`timescale 1ns/1ps
package bgr_pkg;
  typedef enum logic [1:0] {
    GRP_IDLE    = 2'd0,
    GRP_REFRESH = 2'd1,
    GRP_DRAIN   = 2'd2
  } grp_state_t;

  localparam int NUM_GRP = 2;
endpackage

// File: rtl/bgr_decode.sv
`timescale 1ns/1ps
module bgr_decode #(
  parameter int CNT_W   = 10,
  parameter int CNT_MAX = 31
) (
  input  logic             cmd_en,
  input  logic             cmd_special,
  input  logic [CNT_W:0]   cmd_addr,
  input  logic             cmd_grp,
  input  logic [1:0]       grp_idle,
  input  logic [1:0]       grp_refr,
  input  logic [3:0]       bank_pre,
  output logic [1:0]       start,
  output logic [1:0]       stop,
  output logic             bad_cnt,
  output logic             bad_ovl,
  output logic             bad_pre,
  output logic             bad_exit
);
  logic             is_entry;
  logic             is_exit;
  logic [CNT_W-1:0] cnt;
  logic             cnt_ok;
  logic             all_idle;
  logic             tgt_pre;
  logic             go;

  always_comb begin
    is_entry = cmd_en & cmd_special & ~cmd_addr[CNT_W];
    is_exit  = cmd_en & cmd_special &  cmd_addr[CNT_W];
    cnt      = cmd_addr[CNT_W-1:0];
    cnt_ok   = (cnt != '0) && (cnt <= CNT_W'(CNT_MAX));
    all_idle = &grp_idle;
    tgt_pre  = cmd_grp ? (&bank_pre[3:2]) : (&bank_pre[1:0]);

    // priority: count, then overlap, then precharge
    bad_cnt  = is_entry & ~cnt_ok;
    bad_ovl  = is_entry &  cnt_ok & ~all_idle;
    bad_pre  = is_entry &  cnt_ok &  all_idle & ~tgt_pre;
    go       = is_entry &  cnt_ok &  all_idle &  tgt_pre;

    start    = go ? (cmd_grp ? 2'b10 : 2'b01) : 2'b00;
    bad_exit = is_exit & ~(|grp_refr);
    stop     = is_exit ? grp_refr : 2'b00;
  end
endmodule

// File: rtl/bgr_group.sv
`timescale 1ns/1ps
module bgr_group
  import bgr_pkg::*;
#(
  parameter int TREFC   = 4,
  parameter int CNT_MAX = 31,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [CW-1:0] cnt,
  output logic          busy,
  output logic          refr,
  output logic          idle
);
  localparam int TMR_W = $clog2(CNT_MAX * TREFC + 1);

  grp_state_t       st;
  logic [TMR_W-1:0] rem;
  logic [TMR_W-1:0] load;

  always_comb load = TMR_W'(cnt) * TMR_W'(TREFC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= GRP_IDLE;
      rem <= '0;
    end else begin
      case (st)
        GRP_IDLE: begin
          if (start) begin
            st  <= GRP_REFRESH;
            rem <= load;
          end
        end
        GRP_REFRESH: begin
          if (stop) begin
            st  <= GRP_DRAIN;
            rem <= TMR_W'(TREFC);
          end else if (rem == TMR_W'(1)) begin
            st  <= GRP_IDLE;
            rem <= '0;
          end else begin
            rem <= rem - TMR_W'(1);
          end
        end
        GRP_DRAIN: begin
          if (rem == TMR_W'(1)) begin
            st  <= GRP_IDLE;
            rem <= '0;
          end else begin
            rem <= rem - TMR_W'(1);
          end
        end
        default: begin
          st  <= GRP_IDLE;
          rem <= '0;
        end
      endcase
    end
  end

  assign busy = (st != GRP_IDLE);
  assign refr = (st == GRP_REFRESH);
  assign idle = (st == GRP_IDLE);
endmodule

// File: rtl/bgr_quota.sv
`timescale 1ns/1ps
module bgr_quota #(
  parameter int QUOTA = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic win_end,
  input  logic hit,
  output logic miss
);
  localparam int QW = $clog2(QUOTA + 1);

  logic [QW-1:0] tally;

  always_ff @(posedge clk) begin
    if (rst) begin
      tally <= '0;
      miss  <= 1'b0;
    end else begin
      miss <= win_end && (tally < QW'(QUOTA));
      if (win_end)
        tally <= hit ? QW'(1) : '0;
      else if (hit && (tally < QW'(QUOTA)))
        tally <= tally + QW'(1);
    end
  end
endmodule

// File: rtl/bg_refresh_ctrl.sv
`timescale 1ns/1ps
module bg_refresh_ctrl
  import bgr_pkg::*;
#(
  parameter int TREFC    = 8,
  parameter int CNT_W    = 10,
  parameter int CNT_MAX  = 31,
  parameter int TREF_CYC = 1000000,
  parameter int QUOTA    = 8192
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_en,
  input  logic           cmd_special,
  input  logic [CNT_W:0] cmd_addr,
  input  logic           cmd_grp,
  input  logic [3:0]     bank_pre,
  input  logic           acc_req,
  input  logic [1:0]     acc_bank,
  output logic [3:0]     bank_busy,
  output logic           err_count,
  output logic           err_overlap,
  output logic           err_precharge,
  output logic           err_exit,
  output logic           err_access,
  output logic [1:0]     quota_miss
);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int WW = (TREF_CYC > 1) ? $clog2(TREF_CYC) : 1;

  logic [NUM_GRP-1:0] start, stop, g_busy, g_refr, g_idle;
  logic               bad_cnt, bad_ovl, bad_pre, bad_exit;
  logic [WW-1:0]      wcnt;
  logic               win_end;

  bgr_decode #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_dec (
    .cmd_en(cmd_en), .cmd_special(cmd_special), .cmd_addr(cmd_addr),
    .cmd_grp(cmd_grp), .grp_idle(g_idle), .grp_refr(g_refr),
    .bank_pre(bank_pre), .start(start), .stop(stop),
    .bad_cnt(bad_cnt), .bad_ovl(bad_ovl), .bad_pre(bad_pre),
    .bad_exit(bad_exit)
  );

  always_comb win_end = (wcnt == WW'(TREF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst)          wcnt <= '0;
    else if (win_end) wcnt <= '0;
    else              wcnt <= wcnt + WW'(1);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    bgr_group #(.TREFC(TREFC), .CNT_MAX(CNT_MAX), .CW(CW)) u_grp (
      .clk(clk), .rst(rst), .start(start[g]), .stop(stop[g]),
      .cnt(cmd_addr[CW-1:0]), .busy(g_busy[g]), .refr(g_refr[g]),
      .idle(g_idle[g])
    );
    bgr_quota #(.QUOTA(QUOTA)) u_quota (
      .clk(clk), .rst(rst), .win_end(win_end), .hit(start[g]),
      .miss(quota_miss[g])
    );
  end

  assign bank_busy = {g_busy[1], g_busy[1], g_busy[0], g_busy[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_count     <= 1'b0;
      err_overlap   <= 1'b0;
      err_precharge <= 1'b0;
      err_exit      <= 1'b0;
      err_access    <= 1'b0;
    end else begin
      err_count     <= bad_cnt;
      err_overlap   <= bad_ovl;
      err_precharge <= bad_pre;
      err_exit      <= bad_exit;
      err_access    <= acc_req && bank_busy[acc_bank];
    end
  end
endmodule

// File: rtl/bg_refresh_ctrl_chk.sv
`timescale 1ns/1ps
module bg_refresh_ctrl_chk #(
  parameter int CNT_W = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_en,
  input logic           cmd_special,
  input logic [CNT_W:0] cmd_addr,
  input logic           cmd_grp,
  input logic           acc_req,
  input logic [3:0]     bank_busy,
  input logic           err_count,
  input logic           err_overlap,
  input logic           err_precharge,
  input logic           err_exit,
  input logic           err_access
);
  // R7: the two pairs are never busy together
  a_r7_one_group: assert property (@(posedge clk) disable iff (rst)
    !(bank_busy[0] && bank_busy[2]));

  // R2 R3: pair 0 only becomes busy after an entry aimed at it
  a_r3_busy_from_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(bank_busy[0]) |->
      $past(cmd_en && cmd_special && !cmd_addr[CNT_W] && !cmd_grp));

  // R5: a count error follows an entry command
  a_r5_count_cause: assert property (@(posedge clk) disable iff (rst)
    err_count |-> $past(cmd_en && cmd_special && !cmd_addr[CNT_W]));

  // R5 R6 R7 R9: one command raises at most one flag
  a_r5_single_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_count, err_overlap, err_precharge, err_exit}));

  // R9: an exit error follows an exit command
  a_r9_exit_cause: assert property (@(posedge clk) disable iff (rst)
    err_exit |-> $past(cmd_en && cmd_special && cmd_addr[CNT_W]));

  // R10: an access error follows a request
  a_r10_access_cause: assert property (@(posedge clk) disable iff (rst)
    err_access |-> $past(acc_req));
endmodule

bind bg_refresh_ctrl bg_refresh_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_special(cmd_special),
  .cmd_addr(cmd_addr), .cmd_grp(cmd_grp), .acc_req(acc_req),
  .bank_busy(bank_busy), .err_count(err_count), .err_overlap(err_overlap),
  .err_precharge(err_precharge), .err_exit(err_exit),
  .err_access(err_access)
);

// File: tb/sim_bg_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_bg_refresh_ctrl;
  localparam int T  = 3;
  localparam int WN = 200;
  localparam int Q  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_en = 1'b0, cmd_special = 1'b0, cmd_grp = 1'b0;
  logic [10:0] cmd_addr = '0;
  logic [3:0]  bank_pre = 4'hF;
  logic        acc_req = 1'b0;
  logic [1:0]  acc_bank = '0;
  logic [3:0]  bank_busy;
  logic        err_count, err_overlap, err_precharge, err_exit, err_access;
  logic [1:0]  quota_miss;
  int          tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  bg_refresh_ctrl #(.TREFC(T), .CNT_W(10), .CNT_MAX(31), .TREF_CYC(WN),
                    .QUOTA(Q)) u0 (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_special(cmd_special),
    .cmd_addr(cmd_addr), .cmd_grp(cmd_grp), .bank_pre(bank_pre),
    .acc_req(acc_req), .acc_bank(acc_bank), .bank_busy(bank_busy),
    .err_count(err_count), .err_overlap(err_overlap),
    .err_precharge(err_precharge), .err_exit(err_exit),
    .err_access(err_access), .quota_miss(quota_miss)
  );

  // flags packed as {count, overlap, precharge, exit, access}
  function automatic int errs();
    return {27'd0, err_count, err_overlap, err_precharge, err_exit, err_access};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cmd(input bit en, input bit sp, input bit ex, input bit g,
                     input int n);
    cmd_en = en; cmd_special = sp; cmd_grp = g;
    cmd_addr = {ex, n[9:0]};
    @(negedge clk);
    cmd_en = 1'b0; cmd_special = 1'b0; cmd_addr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && bank_busy != 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk("R1 busy in reset", bank_busy, 0);
    do_reset();
    chk("R1 busy", bank_busy, 0);
    chk("R1 flags", errs(), 0);
    chk("R1 quota", quota_miss, 0);

    // R2: missing strobes do nothing
    cmd(1'b1, 1'b0, 1'b0, 1'b0, 5);
    chk("R2 no special busy", bank_busy, 0);
    chk("R2 no special flags", errs(), 0);
    cmd(1'b0, 1'b1, 1'b0, 1'b1, 5);
    chk("R2 no enable busy", bank_busy, 0);
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 0);
    chk("R2 no enable exit flags", errs(), 0);

    // R3 R4 R5: sweep counts for both groups
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 37; k++) begin
        int n;
        n = (k < 35) ? k : ((k == 35) ? 513 : 1023);
        cmd(1'b1, 1'b1, 1'b0, g[0], n);
        if (n >= 1 && n <= 31) begin
          chk("R5 legal no flag", errs(), 0);
          for (int i = 0; i < n * T; i++) begin
            chk("R3 R4 busy window", bank_busy, (g == 1) ? 12 : 3);
            @(negedge clk);
          end
          chk("R4 idle after window", bank_busy, 0);
        end else begin
          chk("R5 count flag", errs(), 16);
          chk("R5 no refresh", bank_busy, 0);
          @(negedge clk);
          chk("R5 one-cycle pulse", errs(), 0);
        end
      end
    end

    // R6: bank 1 not precharged
    bank_pre = 4'b1101;
    cmd(1'b1, 1'b1, 1'b0, 1'b0, 2);
    chk("R6 precharge flag", errs(), 4);
    chk("R6 no refresh", bank_busy, 0);
    cmd(1'b1, 1'b1, 1'b0, 1'b1, 2);
    chk("R6 other pair ok", bank_busy, 12);
    chk("R6 other pair no flag", errs(), 0);
    wait_idle();
    bank_pre = 4'hF;

    // R7: entries while busy
    cmd(1'b1, 1'b1, 1'b0, 1'b0, 5);
    @(negedge clk);
    cmd(1'b1, 1'b1, 1'b0, 1'b1, 3);
    chk("R7 overlap other group", errs(), 8);
    chk("R7 other group untouched", bank_busy, 3);
    cmd(1'b1, 1'b1, 1'b0, 1'b0, 3);
    chk("R7 overlap same group", errs(), 8);
    cmd(1'b1, 1'b1, 1'b0, 1'b1, 40);
    chk("R7 count outranks overlap", errs(), 16);
    // 4 cycles used of 15
    for (int i = 4; i < 5 * T; i++) begin
      chk("R7 original window kept", bank_busy, 3);
      @(negedge clk);
    end
    chk("R7 idle", bank_busy, 0);

    // R9: exit when idle
    cmd(1'b1, 1'b1, 1'b1, 1'b0, 0);
    chk("R9 exit idle flag", errs(), 2);
    chk("R9 exit idle busy", bank_busy, 0);

    // R8 R9: early exit and exit during drain
    cmd(1'b1, 1'b1, 1'b0, 1'b1, 10);
    repeat (4) @(negedge clk);
    cmd(1'b1, 1'b1, 1'b1, 1'b0, 0);
    chk("R8 exit no flag", errs(), 0);
    chk("R8 drain 1", bank_busy, 12);
    cmd(1'b1, 1'b1, 1'b1, 1'b1, 0);
    chk("R9 exit while draining flag", errs(), 2);
    chk("R8 drain 2", bank_busy, 12);
    @(negedge clk);
    chk("R8 drain 3", bank_busy, 12);
    @(negedge clk);
    chk("R8 idle after drain", bank_busy, 0);

    // R10: access checks
    cmd(1'b1, 1'b1, 1'b0, 1'b0, 4);
    acc_req = 1'b1; acc_bank = 2'd1;
    @(negedge clk);
    chk("R10 busy bank access", errs(), 1);
    acc_bank = 2'd2;
    @(negedge clk);
    chk("R10 free bank access", errs(), 0);
    acc_bank = 2'd0;
    @(negedge clk);
    chk("R10 busy bank 0 access", errs(), 1);
    acc_req = 1'b0;
    @(negedge clk);
    chk("R10 pulse ends", errs(), 0);
    wait_idle();
    acc_req = 1'b1; acc_bank = 2'd1;
    @(negedge clk);
    chk("R10 after idle", errs(), 0);
    acc_req = 1'b0;

    // R11: quota windows
    do_reset();
    for (int i = 0; i < Q; i++) begin
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 1);
      repeat (4) @(negedge clk);
    end
    while (cyc < WN - 1) @(negedge clk);
    chk("R11 before close", quota_miss, 0);
    @(negedge clk);
    chk("R11 window 1", quota_miss, 2);
    @(negedge clk);
    chk("R11 pulse ends", quota_miss, 0);
    for (int i = 0; i < Q - 1; i++) begin
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 1);
      repeat (4) @(negedge clk);
    end
    for (int i = 0; i < Q + 1; i++) begin
      cmd(1'b1, 1'b1, 1'b0, 1'b1, 1);
      repeat (4) @(negedge clk);
    end
    while (cyc < 2 * WN - 1) @(negedge clk);
    chk("R11 before close 2", quota_miss, 0);
    @(negedge clk);
    chk("R11 window 2 saturate", quota_miss, 1);
    @(negedge clk);
    chk("R11 pulse ends 2", quota_miss, 0);

    finish_run();
  end
endmodule